// File: doc/BRIEF.md
# Bus-Error Capture and Channel-Check Interrupt Source

This block watches the backplane bus-error line while the local processor runs a master cycle. It turns such an error into a sticky channel-check condition. A captured error drives the same non-maskable interrupt request as a parity error on the local I/O channel, so the interrupt handler sees one combined error source. Software controls the block through three byte-wide registers:

- **Control register:** arms or disarms the capture.
- **Status register:** shows whether an error is held.
- **System control port:** carries the clear/arm bit and shows the channel-error flag.

The bus-error input is asynchronous. It passes through a flip-flop synchroniser and a rising-edge detector. The master-cycle qualifier goes through an equal delay so that the two stay aligned. One error event therefore sets the capture flag once. A level that stays asserted does not set it again after a clear. While the clear bit of the system port is 1, the flag is forced clear. Software writes 1 to the clear bit and then 0 to re-arm the capture.

Top module: `buserr_nmi_unit`

## Requirements
- R1: After a synchronous active-low reset, the capture flag is 0, the arm bit is 0 and the clear bit is 0. With the parity input low, every register reads 0 and `nmi_o` is 0.
- R2: Register map (byte data).
  - Address 0: arm bit at bit 0, read/write.
  - Address 1: capture flag at bit 0, read-only.
  - Address 2: clear bit at bit 3 (read/write) and channel-error flag at bit 6 (read-only).
  - Every other bit reads 0. Address 3 reads 0. A write takes effect at the clock edge that samples it.
- R3: The flag becomes 1 under the following conditions:
  - The arm bit is 1 and the clear bit is 0.
  - `bus_err_i` rises, and `master_cyc_i` is high at the same clock edge that first samples the new high level.
  - When both inputs are held from edge E1, `latch_o` reads 1 after edge E3 and still 0 after edge E2.
- R4: When the arm bit is 0, a qualified bus error leaves the flag at 0.
- R5: A bus error that arrives while `master_cyc_i` is low leaves the flag at 0.
- R6: A bus-error level held high sets the flag only once. After a clear and re-arm, the flag stays 0 until the input falls and then rises again.
- R7: Once set, the flag stays 1 whatever the bus-error, master and parity inputs do, until a clear.
- R8: The flag is cleared at the edge after the clock edge that stores clear bit = 1. It is held at 0 for as long as the clear bit stays 1, even for qualified bus errors.
- R9: Status bit 0 equals the flag. System-port bit 6 equals the flag OR `parity_err_i`.
- R10: `nmi_o` is the level OR of the flag and `parity_err_i`.
- R11: Writes to address 1 and to system-port bit 6 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_err_i | input | 1 | Asynchronous backplane bus-error, active high |
| master_cyc_i | input | 1 | High while the local board runs a master cycle |
| parity_err_i | input | 1 | External channel parity-error level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| latch_o | output | 1 | Sticky bus-error capture flag |
| nmi_o | output | 1 | Channel-check interrupt request, level |

## Verification
The bench builds the block with its defaults: two synchroniser stages, a two-bit address and eight-bit data. With these values, the three-edge capture latency of R3 can be counted exactly. The unmapped fourth address and the read-as-zero upper bits are also reachable. A cycle model in the bench tracks the synchroniser, edge detector, arm and clear bits through thousands of random cycles. Directed sequences cover held errors across a clear, a disarmed capture, errors outside master cycles, and a clear that coincides with an error.

// File: rtl/buserr_pkg.sv
// Package: register addresses and bit positions shared by the
// bus-error capture block, its checker and its bench.
package buserr_pkg;
    localparam int unsigned ADDR_CTRL = 0;  // arm register
    localparam int unsigned ADDR_STAT = 1;  // status register
    localparam int unsigned ADDR_SYS  = 2;  // system control port
    localparam int unsigned BIT_ARM   = 0;
    localparam int unsigned BIT_FLAG  = 0;
    localparam int unsigned BIT_CLR   = 3;
    localparam int unsigned BIT_CHK   = 6;
endpackage

// File: rtl/buserr_edge_sync.sv
// Synchronises the asynchronous bus-error level through STAGES flops
// and flags its rising edge. The master-cycle qualifier passes through
// the same number of flops so both describe the same sampling edge.
// Assumes STAGES >= 2 and a synchronous qualifier.
module buserr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    input  logic qual_i,
    output logic rise_o,
    output logic qual_o
);
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] qual_q;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[0] <= 1'b0;
                    qual_q[0] <= 1'b0;
                end else begin
                    sync_q[0] <= async_i;
                    qual_q[0] <= qual_i;
                end
            end
        end else begin : g_next
            // Later stages: shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                    qual_q[g] <= 1'b0;
                end else begin
                    sync_q[g] <= sync_q[g-1];
                    qual_q[g] <= qual_q[g-1];
                end
            end
        end
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
    assign qual_o = qual_q[STAGES-1];
endmodule

// File: rtl/buserr_regs.sv
// Register file: arm bit, clear bit, and read-back mux for the three
// software-visible registers. Status and channel flags are read-only.
module buserr_regs
    import buserr_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              flag_i,
    input  logic              chan_err_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              arm_o,
    output logic              clr_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(ADDR_SYS);

    logic arm_q;
    logic clr_q;
    wire  unused_wdata = ^wdata_i;

    // Arm bit store.
    always_ff @(posedge clk) begin
        if (!rst_n)                       arm_q <= 1'b0;
        else if (wr_i && addr_i == A_CTRL) arm_q <= wdata_i[BIT_ARM];
    end

    // Clear bit store in the system port.
    always_ff @(posedge clk) begin
        if (!rst_n)                      clr_q <= 1'b0;
        else if (wr_i && addr_i == A_SYS) clr_q <= wdata_i[BIT_CLR];
    end

    // Read-back mux; unmapped bits and addresses read 0.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: rdata_o[BIT_ARM] = arm_q;
            A_STAT: rdata_o[BIT_FLAG] = flag_i;
            A_SYS: begin
                rdata_o[BIT_CLR] = clr_q;
                rdata_o[BIT_CHK] = chan_err_i;
            end
            default: rdata_o = '0;
        endcase
    end

    assign arm_o = arm_q;
    assign clr_o = clr_q;
endmodule

// File: rtl/buserr_latch.sv
// Sticky capture flag and interrupt merge. Clear has priority over set;
// a set needs an aligned edge, the qualifier and the arm bit.
module buserr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic qual_i,
    input  logic arm_i,
    input  logic clr_i,
    input  logic parity_i,
    output logic flag_o,
    output logic chan_err_o,
    output logic nmi_o
);
    logic flag_q;

    // Capture flag: clear wins, then qualified set, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                        flag_q <= 1'b0;
        else if (clr_i)                    flag_q <= 1'b0;
        else if (rise_i && qual_i && arm_i) flag_q <= 1'b1;
    end

    assign flag_o     = flag_q;
    assign chan_err_o = flag_q | parity_i;
    assign nmi_o      = flag_q | parity_i;
endmodule

// File: rtl/buserr_nmi_unit.sv
// Top: bus-error capture merged into the channel-check interrupt path.
// Assumes bus_err_i is asynchronous and all other inputs are synchronous.
module buserr_nmi_unit #(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_err_i,
    input  logic              master_cyc_i,
    input  logic              parity_err_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              latch_o,
    output logic              nmi_o
);
    logic edge_rise;
    logic edge_qual;
    logic ctrl_arm;
    logic sys_clr;
    logic chan_err;

    buserr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_err_i),
        .qual_i  (master_cyc_i),
        .rise_o  (edge_rise),
        .qual_o  (edge_qual)
    );

    buserr_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (edge_rise),
        .qual_i     (edge_qual),
        .arm_i      (ctrl_arm),
        .clr_i      (sys_clr),
        .parity_i   (parity_err_i),
        .flag_o     (latch_o),
        .chan_err_o (chan_err),
        .nmi_o      (nmi_o)
    );

    buserr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .flag_i     (latch_o),
        .chan_err_i (chan_err),
        .rdata_o    (reg_rdata_o),
        .arm_o      (ctrl_arm),
        .clr_o      (sys_clr)
    );
endmodule

// File: rtl/buserr_nmi_unit_chk.sv
// Checker: temporal properties of the capture flag, clear, arm and
// interrupt merge. Attached to the top by bind below.
module buserr_nmi_unit_chk
    import buserr_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              parity_err_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              latch_o,
    input logic              nmi_o,
    input logic              ctrl_arm,
    input logic              sys_clr,
    input logic              edge_rise,
    input logic              edge_qual
);
    // R10: a held flag always requests the interrupt.
    p_flag_nmi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> nmi_o);

    // R10: parity error reaches the interrupt too.
    p_parity_nmi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err_i |-> nmi_o);

    // R8: writing the clear bit empties the flag one edge later.
    p_clear_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_SYS) && reg_wdata_i[BIT_CLR])
        |=> ##1 !latch_o);

    // R8: a stored clear bit holds the flag at 0.
    p_clear_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clr |=> !latch_o);

    // R4: a disarmed block never sets the flag.
    p_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_arm && !latch_o) |=> !latch_o);

    // R7: the flag is sticky until a clear.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o && !sys_clr) |=> latch_o);

    // R3: a set always follows an aligned, qualified edge.
    p_set_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_o) |-> $past(edge_rise && edge_qual));

    // R9: status bit 0 mirrors the flag.
    p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(ADDR_STAT)) |-> (reg_rdata_o[BIT_FLAG] == latch_o));
endmodule

bind buserr_nmi_unit buserr_nmi_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .parity_err_i (parity_err_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .latch_o      (latch_o),
    .nmi_o        (nmi_o),
    .ctrl_arm     (ctrl_arm),
    .sys_clr      (sys_clr),
    .edge_rise    (edge_rise),
    .edge_qual    (edge_qual)
);

// File: tb/buserr_nmi_unit_tb.sv
`timescale 1ns/1ps
module buserr_nmi_unit_tb;
    localparam int AW = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_err = 1'b0, master = 1'b0, parity = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          latch, nmi;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Bench model state (two synchroniser stages, as specified).
    logic m_s0, m_s1, m_last, m_q0, m_q1, m_arm, m_clr, m_flag;

    always #10 clk = ~clk;  // 50 MHz

    buserr_nmi_unit #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_err_i(bus_err), .master_cyc_i(master),
        .parity_err_i(parity), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .latch_o(latch), .nmi_o(nmi)
    );

    function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
        logic [DW-1:0] r = '0;
        case (a)
            2'd0: r[0] = m_arm;
            2'd1: r[0] = m_flag;
            2'd2: begin r[3] = m_clr; r[6] = m_flag | parity; end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        {m_s0, m_s1, m_last, m_q0, m_q1, m_arm, m_clr, m_flag} = '0;
    endtask

    // One clock: advance model with the applied inputs, then compare.
    task automatic tick(string tag);
        logic n_flag, n_arm, n_clr;
        n_flag = m_clr ? 1'b0 : ((m_s1 & ~m_last & m_q1 & m_arm) ? 1'b1 : m_flag);
        n_arm  = (wr && addr == 2'd0) ? wdata[0] : m_arm;
        n_clr  = (wr && addr == 2'd2) ? wdata[3] : m_clr;
        @(posedge clk);
        m_last = m_s1; m_s1 = m_s0; m_s0 = bus_err;
        m_q1 = m_q0; m_q0 = master;
        m_flag = n_flag; m_arm = n_arm; m_clr = n_clr;
        @(negedge clk);
        check({tag, " R9 latch"}, 32'(latch), 32'(m_flag));
        check({tag, " R10 nmi"}, 32'(nmi), 32'(m_flag | parity));
        check({tag, " R2 rdata"}, 32'(rdata), 32'(exp_rd(addr)));
    endtask

    task automatic wr_reg(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        wr = 1'b1; addr = a; wdata = d;
        tick(tag);
        wr = 1'b0; wdata = '0;
    endtask

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        #(20.0 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state on every address.
        for (int a = 0; a < 4; a++) begin
            addr = AW'(a); #1;
            check("R1 reset rdata", 32'(rdata), 0);
        end
        check("R1 reset latch", 32'(latch), 0);
        check("R1 reset nmi", 32'(nmi), 0);
        rst_n = 1'b1; addr = '0;
        tick("R1");

        // R2: arm bit write/readback and unmapped bits.
        wr_reg(2'd0, 8'hFF, "R2");
        addr = 2'd0; #1; check("R2 arm readback", 32'(rdata), 32'h01);
        addr = 2'd3; #1; check("R2 unmapped addr", 32'(rdata), 0);

        // R3: latency of exactly three edges.
        bus_err = 1'b1; master = 1'b1; addr = 2'd1;
        tick("R3"); tick("R3");
        check("R3 not yet after E2", 32'(latch), 0);
        tick("R3");
        check("R3 set after E3", 32'(latch), 1);
        addr = 2'd2; #1; check("R9 chan flag", 32'(rdata), 32'h40);

        // R7: sticky across input activity.
        bus_err = 1'b0; master = 1'b0; parity = 1'b1;
        repeat (4) tick("R7");
        parity = 1'b0; tick("R7");
        check("R7 still set", 32'(latch), 1);

        // R11: writes to status and bit 6 change nothing.
        wr_reg(2'd1, 8'h00, "R11");
        wr_reg(2'd2, 8'h40, "R11");
        addr = 2'd1; tick("R11");
        check("R11 flag kept", 32'(latch), 1);
        addr = 2'd2; #1; check("R11 sys port", 32'(rdata), 32'h40);

        // R8: clear, and held clear against a qualified error.
        wr_reg(2'd2, 8'h08, "R8");
        bus_err = 1'b1; master = 1'b1;
        tick("R8");
        check("R8 cleared", 32'(latch), 0);
        repeat (4) tick("R8");
        check("R8 held clear", 32'(latch), 0);

        // R6: held level does not re-set after re-arm.
        wr_reg(2'd2, 8'h00, "R6");
        repeat (5) tick("R6");
        check("R6 no re-set on held level", 32'(latch), 0);
        bus_err = 1'b0; repeat (3) tick("R6");
        bus_err = 1'b1; repeat (3) tick("R6");
        check("R6 new edge sets", 32'(latch), 1);

        // R4: disarmed block ignores an error.
        wr_reg(2'd2, 8'h08, "R4"); wr_reg(2'd2, 8'h00, "R4");
        wr_reg(2'd0, 8'h00, "R4");
        bus_err = 1'b0; repeat (3) tick("R4");
        bus_err = 1'b1; repeat (5) tick("R4");
        check("R4 disarmed stays 0", 32'(latch), 0);

        // R5: error outside a master cycle.
        wr_reg(2'd0, 8'h01, "R5");
        bus_err = 1'b0; master = 1'b0; repeat (3) tick("R5");
        bus_err = 1'b1; repeat (5) tick("R5");
        check("R5 no master stays 0", 32'(latch), 0);

        // R10: parity alone raises the interrupt.
        parity = 1'b1; tick("R10");
        check("R10 parity nmi", 32'(nmi), 1);
        parity = 1'b0; bus_err = 1'b0;

        // Random phase checked against the bench model.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 8 == 0) bus_err = ~bus_err;
            if ($urandom % 4 == 0) master = ~master;
            parity = ($urandom % 16 == 0);
            addr   = AW'($urandom);
            wr     = ($urandom % 12 == 0);
            wdata  = DW'($urandom);
            if (addr == 2'd2) wdata[3] = ($urandom % 4 == 0);
            if (addr == 2'd0) wdata[0] = ($urandom % 5 != 0);
            tick("R3 random");
        end
        wr = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule